// File: doc/BRIEF.md
# Vector Length Setup Unit

This unit executes the instruction that configures vector length. It accepts one 32-bit instruction word per cycle, together with the value read from the general-purpose register that the word names as its source and the current maximum vector length (MVL) and vector length (VL). One cycle later it returns the new MVL and VL, each with its own write enable. It also returns a destination register write, a condition-field update and an illegal-instruction flag. The register file, the pipeline and the rest of the decoder sit outside the unit and act on these outputs.

Lengths taken from the immediate are stored as the field value plus one, so an immediate can give a length from 1 to 64 but never 0. MVL comes either from the immediate or from its current value. VL comes from its current value, from the immediate, or from the source register. VL is always limited to the new MVL. Loop code uses the destination register write to learn how many elements the current pass handles.

There is no back-pressure. The unit accepts a word in every cycle in which `in_valid` is high and has no ready signal. The consumer must take each result in the cycle where `out_valid` is high. The data outputs mean something only where their own enable is high.

Top module: `vl_setup_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. Every write enable and `illegal` is low in any cycle where `out_valid` is low. Reset clears all outputs to zero.
- R2: Instruction bits are numbered big-endian (bit 0 is `instr[31]`). The destination index is bits 6..10 (`instr[25:21]`), the source index is bits 11..15 (`instr[20:16]`), the 6 usable immediate bits are bits 16..21 (`instr[15:10]`), the VL-select flag is bit 24 (`instr[7]`), the MVL-select flag is bit 25 (`instr[6]`) and the record flag is bit 31 (`instr[0]`).
- R3: When the primary opcode (`instr[31:26]`) equals 19 and reserved bit 22 (`instr[9]`) is 1, `illegal` is raised and all of `vl_wr`, `mvl_wr`, `rd_wr` and `cr_wr` stay low.
- R4: The length given by the immediate is the 6-bit field plus one: 0 gives 1 and 63 gives 64. No immediate produces a length of 0.
- R5: When the MVL-select flag is 1, `mvl_out` is the immediate length and `mvl_wr` is 1. When the flag is 0, `mvl_wr` is 0 and `mvl_out` equals `cur_mvl`.
- R6: When the VL-select flag is 1, VL comes from `src_val` if the source index is nonzero, and from the immediate length if the index is 0. When the flag is 0, VL comes from `cur_vl`. On every legal instruction `vl_wr` is 1.
- R7: `vl_out` is the selected VL limited to the new MVL. This holds for any 64-bit `src_val`, however large.
- R8: On a legal instruction whose destination index is nonzero, `rd_wr` is 1, `rd_idx` is that index and `rd_data` is `vl_out` zero-extended. A destination index of 0 gives no register write.
- R9: On a legal instruction whose record flag is 1, `cr_wr` is 1 and `cr_field` is computed from the new VL: 4'b0010 when VL is 0, otherwise 4'b0100.
- R10: A valid word whose primary opcode is not 19 raises `out_valid` but drives no write enable and no `illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | XLEN | Value of the named source register |
| cur_mvl | input | 7 | Current maximum vector length |
| cur_vl | input | 7 | Current vector length |
| out_valid | output | 1 | Result of last cycle's instruction |
| illegal | output | 1 | Reserved bit was set; no state changes |
| mvl_wr | output | 1 | Write enable for MVL |
| mvl_out | output | 7 | New MVL |
| vl_wr | output | 1 | Write enable for VL |
| vl_out | output | 7 | New VL |
| rd_wr | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination register data |
| cr_wr | output | 1 | Condition field write enable |
| cr_field | output | 4 | Condition field value |

## Verification
Every result of this unit is due exactly one clock edge after the cycle in which its word was presented. This applies to the new lengths, the register write, the condition field and the illegal flag, because one register stage holds all of them. The bench changes its inputs at the falling edge and holds `in_valid` for one cycle. It then reads all outputs at the next falling edge, which comes half a period after the capturing rising edge. One cycle later it confirms that `out_valid` and the enables have fallen again.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int          VLS_IMM_W  = 6;
  localparam int          VLS_LEN_W  = VLS_IMM_W + 1;
  localparam int          VLS_IDX_W  = 5;
  localparam logic [5:0]  VLS_OPCODE = 6'd19;
  localparam logic [3:0]  VLS_CR_EQ  = 4'b0010;
  localparam logic [3:0]  VLS_CR_GT  = 4'b0100;

  typedef struct packed {
    logic [5:0]           opcode;
    logic [VLS_IDX_W-1:0] rt;
    logic [VLS_IDX_W-1:0] ra;
    logic [VLS_IMM_W-1:0] imm;
    logic                 rsv;
    logic                 vs;
    logic                 ms;
    logic                 rc;
  } vls_fields_t;

  typedef enum logic [1:0] {VL_KEEP, VL_IMM, VL_REG} vl_src_e;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
(
  input  logic [31:0]  instr,
  output vls_fields_t  fields,
  output logic         match
);
  // big-endian numbering: bit k of the format is instr[31-k]
  assign fields.opcode = instr[31:26];
  assign fields.rt     = instr[25:21];
  assign fields.ra     = instr[20:16];
  assign fields.imm    = instr[15:10];
  assign fields.rsv    = instr[9];
  assign fields.vs     = instr[7];
  assign fields.ms     = instr[6];
  assign fields.rc     = instr[0];
  assign match         = (instr[31:26] == VLS_OPCODE);

  logic unused_bits;
  assign unused_bits = ^{instr[8], instr[5:1]};
endmodule

// File: rtl/vls_len_select.sv
module vls_len_select
  import vls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [VLS_IMM_W-1:0] imm,
  input  logic [VLS_IDX_W-1:0] ra,
  input  logic                 vs,
  input  logic                 ms,
  input  logic [XLEN-1:0]      src_val,
  input  logic [VLS_LEN_W-1:0] cur_mvl,
  input  logic [VLS_LEN_W-1:0] cur_vl,
  output logic [VLS_LEN_W-1:0] mvl_new,
  output logic [VLS_LEN_W-1:0] vl_new
);
  localparam int LW = VLS_LEN_W;

  logic [LW-1:0] imm_len, src_fit, cand;
  vl_src_e       sel;

  assign imm_len = LW'(imm) + LW'(1);
  assign mvl_new = ms ? imm_len : cur_mvl;

  always_comb begin
    if (!vs)            sel = VL_KEEP;
    else if (ra != '0)  sel = VL_REG;
    else                sel = VL_IMM;
  end

  // compare at full register width so large values clip correctly
  assign src_fit = (src_val > XLEN'(mvl_new)) ? mvl_new : src_val[LW-1:0];

  always_comb begin
    unique case (sel)
      VL_REG:  cand = src_fit;
      VL_IMM:  cand = imm_len;
      default: cand = cur_vl;
    endcase
  end

  assign vl_new = (cand > mvl_new) ? mvl_new : cand;
endmodule

// File: rtl/vls_cr_gen.sv
module vls_cr_gen
  import vls_pkg::*;
(
  input  logic [VLS_LEN_W-1:0] vl,
  output logic [3:0]           cr
);
  assign cr = (vl == '0) ? VLS_CR_EQ : VLS_CR_GT;
endmodule

// File: rtl/vl_setup_unit.sv
module vl_setup_unit
  import vls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [31:0]          instr,
  input  logic [XLEN-1:0]      src_val,
  input  logic [VLS_LEN_W-1:0] cur_mvl,
  input  logic [VLS_LEN_W-1:0] cur_vl,
  output logic                 out_valid,
  output logic                 illegal,
  output logic                 mvl_wr,
  output logic [VLS_LEN_W-1:0] mvl_out,
  output logic                 vl_wr,
  output logic [VLS_LEN_W-1:0] vl_out,
  output logic                 rd_wr,
  output logic [VLS_IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]      rd_data,
  output logic                 cr_wr,
  output logic [3:0]           cr_field
);
  vls_fields_t          f;
  logic                 match, fire, legal;
  logic [VLS_LEN_W-1:0] mvl_new, vl_new;
  logic [3:0]           cr_new;

  vls_decode u_dec (.instr(instr), .fields(f), .match(match));

  vls_len_select #(.XLEN(XLEN)) u_len (
    .imm(f.imm), .ra(f.ra), .vs(f.vs), .ms(f.ms), .src_val(src_val),
    .cur_mvl(cur_mvl), .cur_vl(cur_vl), .mvl_new(mvl_new), .vl_new(vl_new)
  );

  vls_cr_gen u_cr (.vl(vl_new), .cr(cr_new));

  assign fire  = in_valid && match;
  assign legal = fire && !f.rsv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      mvl_wr    <= 1'b0;
      mvl_out   <= '0;
      vl_wr     <= 1'b0;
      vl_out    <= '0;
      rd_wr     <= 1'b0;
      rd_idx    <= '0;
      rd_data   <= '0;
      cr_wr     <= 1'b0;
      cr_field  <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= fire && f.rsv;
      mvl_wr    <= legal && f.ms;
      vl_wr     <= legal;
      rd_wr     <= legal && (f.rt != '0);
      cr_wr     <= legal && f.rc;
      if (in_valid) begin
        mvl_out  <= mvl_new;
        vl_out   <= vl_new;
        rd_idx   <= f.rt;
        rd_data  <= XLEN'(vl_new);
        cr_field <= cr_new;
      end
    end
  end
endmodule

// File: rtl/vls_checker.sv
module vls_checker
  import vls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 illegal,
  input logic                 mvl_wr,
  input logic [VLS_LEN_W-1:0] mvl_out,
  input logic                 vl_wr,
  input logic [VLS_LEN_W-1:0] vl_out,
  input logic                 rd_wr,
  input logic [VLS_IDX_W-1:0] rd_idx,
  input logic [XLEN-1:0]      rd_data,
  input logic                 cr_wr,
  input logic [3:0]           cr_field
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_no_stray_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(vl_wr || mvl_wr || rd_wr || cr_wr || illegal));
  assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(vl_wr || mvl_wr || rd_wr || cr_wr));
  assert_mvl_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_wr |-> (mvl_out >= 7'd1 && mvl_out <= 7'd64));
  assert_vl_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vl_wr |-> vl_out <= mvl_out);
  assert_rd_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wr |-> (rd_idx != '0 && rd_data == XLEN'(vl_out)));
  assert_cr_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_wr |-> (vl_out == '0 ? cr_field == 4'b0010 : cr_field == 4'b0100));
endmodule

bind vl_setup_unit vls_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .illegal(illegal), .mvl_wr(mvl_wr), .mvl_out(mvl_out), .vl_wr(vl_wr),
  .vl_out(vl_out), .rd_wr(rd_wr), .rd_idx(rd_idx), .rd_data(rd_data),
  .cr_wr(cr_wr), .cr_field(cr_field)
);

// File: tb/sim_vl_setup_unit.sv
`timescale 1ns/1ps
module sim_vl_setup_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] src_val = '0;
  logic [6:0]      cur_mvl = '0, cur_vl = '0;
  logic            out_valid, illegal, mvl_wr, vl_wr, rd_wr, cr_wr;
  logic [6:0]      mvl_out, vl_out;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_data;
  logic [3:0]      cr_field;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  vl_setup_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .cur_mvl(cur_mvl), .cur_vl(cur_vl),
    .out_valid(out_valid), .illegal(illegal), .mvl_wr(mvl_wr),
    .mvl_out(mvl_out), .vl_wr(vl_wr), .vl_out(vl_out), .rd_wr(rd_wr),
    .rd_idx(rd_idx), .rd_data(rd_data), .cr_wr(cr_wr), .cr_field(cr_field)
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rt,
      input logic [4:0] ra, input logic [5:0] imm, input logic rsv,
      input logic vs, input logic ms, input logic rc);
    logic [31:0] w;
    w = '0;
    w[31:26] = opc; w[25:21] = rt; w[20:16] = ra; w[15:10] = imm;
    w[9] = rsv; w[7] = vs; w[6] = ms; w[0] = rc;
    return w;
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] src;
    logic [6:0]  cmvl, cvl, evl, emvl;
    logic        eill;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{mk(6'd19, 5'd5, 5'd0,  6'd7,  1'b0, 1'b1, 1'b0, 1'b0), 64'd0,   7'd64, 7'd3,  7'd8,  7'd64, 1'b0},
    '{mk(6'd19, 5'd0, 5'd0,  6'd7,  1'b0, 1'b0, 1'b1, 1'b1), 64'd0,   7'd64, 7'd3,  7'd3,  7'd8,  1'b0},
    '{mk(6'd19, 5'd3, 5'd4,  6'd7,  1'b0, 1'b1, 1'b1, 1'b1), 64'd100, 7'd64, 7'd1,  7'd8,  7'd8,  1'b0},
    '{mk(6'd19, 5'd3, 5'd4,  6'd15, 1'b0, 1'b1, 1'b1, 1'b0), 64'd5,   7'd64, 7'd1,  7'd5,  7'd16, 1'b0},
    '{mk(6'd19, 5'd2, 5'd6,  6'd63, 1'b0, 1'b1, 1'b1, 1'b1), 64'd0,   7'd10, 7'd9,  7'd0,  7'd64, 1'b0},
    '{mk(6'd19, 5'd1, 5'd0,  6'd0,  1'b0, 1'b1, 1'b1, 1'b1), 64'd0,   7'd64, 7'd9,  7'd1,  7'd1,  1'b0},
    '{mk(6'd19, 5'd1, 5'd0,  6'd63, 1'b0, 1'b1, 1'b0, 1'b0), 64'd0,   7'd20, 7'd4,  7'd20, 7'd20, 1'b0},
    '{mk(6'd19, 5'd0, 5'd0,  6'd3,  1'b0, 1'b0, 1'b1, 1'b0), 64'd0,   7'd64, 7'd30, 7'd4,  7'd4,  1'b0},
    '{mk(6'd19, 5'd5, 5'd0,  6'd7,  1'b1, 1'b1, 1'b1, 1'b1), 64'd0,   7'd64, 7'd3,  7'd0,  7'd0,  1'b1},
    '{mk(6'd19, 5'd9, 5'd7,  6'd0,  1'b0, 1'b1, 1'b0, 1'b1), 64'h8000_0000_0000_0001, 7'd32, 7'd2, 7'd32, 7'd32, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // present one word for one cycle; results are read at the next falling edge
  task automatic apply(input logic [31:0] w, input logic [63:0] s,
                       input logic [6:0] m, input logic [6:0] v);
    @(negedge clk);
    instr = w; src_val = s; cur_mvl = m; cur_vl = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    chk(req, "out_valid idle", 64'(out_valid), 64'd0);
    chk(req, "enables idle", 64'({vl_wr, mvl_wr, rd_wr, cr_wr, illegal}), 64'd0);
  endtask

  initial begin
    #(4ns * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs",
        64'({out_valid, illegal, mvl_wr, vl_wr, rd_wr, cr_wr, cr_field, rd_idx}), 64'd0);
    chk("R1", "reset vl/mvl", 64'({vl_out, mvl_out}), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      logic exp_rd, exp_mw, exp_cw;
      t = TBL[i];
      exp_mw = !t.eill && t.ins[6];
      exp_rd = !t.eill && (t.ins[25:21] != 5'd0);
      exp_cw = !t.eill && t.ins[0];
      apply(t.ins, t.src, t.cmvl, t.cvl);
      chk("R1", "out_valid", 64'(out_valid), 64'd1);
      chk("R3", "illegal", 64'(illegal), 64'(t.eill));
      chk("R6", "vl_wr", 64'(vl_wr), 64'(!t.eill));
      chk("R5", "mvl_wr", 64'(mvl_wr), 64'(exp_mw));
      chk("R8", "rd_wr", 64'(rd_wr), 64'(exp_rd));
      chk("R9", "cr_wr", 64'(cr_wr), 64'(exp_cw));
      if (!t.eill) begin
        chk("R6/R7", "vl_out", 64'(vl_out), 64'(t.evl));
        chk("R4/R5", "mvl_out", 64'(mvl_out), 64'(t.emvl));
      end
      if (exp_rd) begin
        chk("R2", "rd_idx", 64'(rd_idx), 64'(t.ins[25:21]));
        chk("R8", "rd_data", rd_data, 64'(t.evl));
      end
      if (exp_cw)
        chk("R9", "cr_field", 64'(cr_field), (t.evl == 7'd0) ? 64'h2 : 64'h4);
      check_idle("R1");
    end

    // R10: another opcode with every flag set is ignored
    apply(mk(6'd31, 5'd5, 5'd3, 6'd7, 1'b1, 1'b1, 1'b1, 1'b1), 64'd4, 7'd64, 7'd2);
    chk("R10", "out_valid", 64'(out_valid), 64'd1);
    chk("R10", "no enables", 64'({vl_wr, mvl_wr, rd_wr, cr_wr, illegal}), 64'd0);

    // R7: VL kept from its register but the new MVL is smaller
    apply(mk(6'd19, 5'd4, 5'd0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0), 64'd0, 7'd64, 7'd64);
    chk("R7", "kept vl clipped", 64'(vl_out), 64'd1);
    chk("R8", "rd_data clipped", rd_data, 64'd1);

    // R6: nonzero source index with vs clear keeps cur_vl
    apply(mk(6'd19, 5'd4, 5'd8, 6'd9, 1'b0, 1'b0, 1'b0, 1'b0), 64'd2, 7'd40, 7'd33);
    chk("R6", "vs clear keeps vl", 64'(vl_out), 64'd33);
    chk("R5", "mvl unchanged", 64'(mvl_out), 64'd40);

    // R1: back-to-back words each give a result
    @(negedge clk);
    instr = mk(6'd19, 5'd1, 5'd0, 6'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    instr = mk(6'd19, 5'd1, 5'd0, 6'd11, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1", "first of pair", 64'(vl_out), 64'd6);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "second of pair", 64'(vl_out), 64'd12);
    check_idle("R1");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule